// File: doc/BRIEF.md
# Interrupt Status and Mask Register Block

This block collects single-cycle event pulses from a serial bus controller core and turns them into sticky status bits and one interrupt line. Each source has a status bit and a mask bit, and all four registers share one bit layout: the status register, a read-only mask view, a write-only unmask port and a write-only mask port. Software reads the status register and writes back the value it read to acknowledge. It opens or closes individual sources by writing ones to the unmask or mask port. There is no single read/write enable register.

The interrupt line is registered. It rises one cycle after any status bit whose mask bit is clear becomes set. A second registered line covers only the error group, which is NACK, receive overflow, transmit overflow, receive underflow and arbitration lost. Register access uses a plain strobe port. Read data appears one cycle after the read strobe.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the status register reads 0 and the mask view reads 0x2FF, so every source starts masked. `irq_o`, `err_irq_o` and `reg_rdata_o` are 0.
- R2: An event pulse on `evt_i[n]` sets status bit n at the next clock edge. Bit meanings: 0 completion, 1 data threshold, 2 NACK, 3 timeout, 4 target ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost.
- R3: A write to offset 0x10 clears each status bit written as 1. Bits written as 0 keep their value.
- R4: If an event arrives in the same cycle as a write-1-clear of its own bit, the bit stays set.
- R5: A write to offset 0x28 sets each mask bit written as 1. A write to offset 0x24 clears each mask bit written as 1. Zero bits have no effect. The mask reads back at offset 0x20.
- R6: `irq_o` is 1 in the cycle after the one in which some status bit is 1 and its mask bit is 0. Otherwise it is 0.
- R7: `err_irq_o` follows the same rule as R6, but only for bits 2, 5, 6, 7 and 9.
- R8: Bit 8 and bits 10 and up read as 0. Writes and events do not set them.
- R9: Reads of offsets 0x24, 0x28 and any unmapped offset return 0.
- R10: `reg_rdata_o` carries the addressed register's value from the read cycle, one cycle after `reg_rd_i`. It is 0 in any cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 10 | Event pulses from the controller core, one per source bit |
| reg_addr_i | input | 8 | Byte offset of the register access |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt, any unmasked status bit |
| err_irq_o | output | 1 | Registered interrupt, unmasked error-group bits only |

## Verification
The properties assume that a write strobe and a read strobe never target two different offsets in the same cycle. They also assume that event inputs are meaningful only on the nine defined source bits. The stimulus drives every strobe and event from the falling edge, and it holds each access for exactly one cycle. It deliberately drives the reserved bit 8 and the upper write-data bits, to show that they are dropped. The only overlap it creates on purpose is an event together with a clear of the same status bit.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int SRC_W = 10;

    // source bit positions shared by status, mask, unmask and mask ports
    localparam int B_DONE    = 0;
    localparam int B_THRESH  = 1;
    localparam int B_NACK    = 2;
    localparam int B_TMO     = 3;
    localparam int B_TGT_RDY = 4;
    localparam int B_RX_OVF  = 5;
    localparam int B_TX_OVF  = 6;
    localparam int B_RX_UNF  = 7;
    localparam int B_ARB     = 9;

    localparam logic [SRC_W-1:0] SRC_VALID =
        SRC_W'((1 << B_DONE) | (1 << B_THRESH) | (1 << B_NACK) | (1 << B_TMO) |
               (1 << B_TGT_RDY) | (1 << B_RX_OVF) | (1 << B_TX_OVF) |
               (1 << B_RX_UNF) | (1 << B_ARB));

    localparam logic [SRC_W-1:0] SRC_ERR =
        SRC_W'((1 << B_NACK) | (1 << B_RX_OVF) | (1 << B_TX_OVF) |
               (1 << B_RX_UNF) | (1 << B_ARB));

    localparam int OFF_STATUS = 'h10;
    localparam int OFF_MASK   = 'h20;
    localparam int OFF_UNMASK = 'h24;
    localparam int OFF_SETMSK = 'h28;

endpackage

// File: rtl/evt_irq_status.sv
module evt_irq_status #(
    parameter int                W     = 32,
    parameter logic [W-1:0]      VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] nxt;

    // per-bit sticky cell: a set in the same cycle as a clear wins
    for (genvar i = 0; i < W; i++) begin : g_cell
        assign nxt[i] = VALID[i] ? (set_i[i] | (st_q.bits[i] & ~clr_i[i])) : 1'b0;
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.bits;
endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask #(
    parameter int           W     = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mask_set_i,
    input  logic [W-1:0] mask_clr_i,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } mk_t;

    mk_t mk_d, mk_q;

    always_comb begin
        mk_d      = mk_q;
        mk_d.bits = ((mk_q.bits & ~mask_clr_i) | mask_set_i) & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mk_q.bits <= VALID;
        else        mk_q      <= mk_d;
    end

    assign mask_o = mk_q.bits;
endmodule

// File: rtl/evt_irq_rdmux.sv
module evt_irq_rdmux #(
    parameter int ADDR_W = 8,
    parameter int W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      status_i,
    input  logic [W-1:0]      mask_i,
    output logic [W-1:0]      rdata_o
);
    import evt_irq_pkg::*;

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);

    typedef struct packed {
        logic [W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [W-1:0] sel;

    always_comb begin
        unique case (addr_i)
            A_STATUS: sel = status_i;
            A_MASK:   sel = mask_i;
            default:  sel = '0;
        endcase
        rd_d      = rd_q;
        rd_d.data = rd_i ? sel : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata_o = rd_q.data;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [evt_irq_pkg::SRC_W-1:0] evt_i,
    input  logic [ADDR_W-1:0]          reg_addr_i,
    input  logic                       reg_wr_i,
    input  logic [DATA_W-1:0]          reg_wdata_i,
    input  logic                       reg_rd_i,
    output logic [DATA_W-1:0]          reg_rdata_o,
    output logic                       irq_o,
    output logic                       err_irq_o
);
    import evt_irq_pkg::*;

    localparam logic [DATA_W-1:0] VALID_W  = DATA_W'(SRC_VALID);
    localparam logic [DATA_W-1:0] ERR_W    = DATA_W'(SRC_ERR);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(OFF_UNMASK);
    localparam logic [ADDR_W-1:0] A_SETMSK = ADDR_W'(OFF_SETMSK);

    typedef struct packed {
        logic irq;
        logic err;
    } out_t;

    logic [DATA_W-1:0] evt_w, clr_w, mset_w, mclr_w;
    logic [DATA_W-1:0] status_w, mask_w, live_w;
    out_t out_d, out_q;

    // decode of write strobes into per-bit vectors
    always_comb begin
        evt_w  = DATA_W'(evt_i);
        clr_w  = (reg_wr_i && reg_addr_i == A_STATUS) ? reg_wdata_i : '0;
        mclr_w = (reg_wr_i && reg_addr_i == A_UNMASK) ? reg_wdata_i : '0;
        mset_w = (reg_wr_i && reg_addr_i == A_SETMSK) ? reg_wdata_i : '0;
    end

    evt_irq_status #(.W(DATA_W), .VALID(VALID_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_w),
        .clr_i    (clr_w),
        .status_o (status_w)
    );

    evt_irq_mask #(.W(DATA_W), .VALID(VALID_W)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_set_i (mset_w),
        .mask_clr_i (mclr_w),
        .mask_o     (mask_w)
    );

    evt_irq_rdmux #(.ADDR_W(ADDR_W), .W(DATA_W)) u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (reg_rd_i),
        .addr_i   (reg_addr_i),
        .status_i (status_w),
        .mask_i   (mask_w),
        .rdata_o  (reg_rdata_o)
    );

    assign live_w = status_w & ~mask_w;

    always_comb begin
        out_d     = out_q;
        out_d.irq = |live_w;
        out_d.err = |(live_w & ERR_W);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_o     = out_q.irq;
    assign err_irq_o = out_q.err;
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [evt_irq_pkg::SRC_W-1:0] evt_i,
    input logic [ADDR_W-1:0]             reg_addr_i,
    input logic                          reg_wr_i,
    input logic [DATA_W-1:0]             reg_wdata_i,
    input logic                          reg_rd_i,
    input logic [DATA_W-1:0]             reg_rdata_o,
    input logic                          irq_o,
    input logic                          err_irq_o,
    input logic [DATA_W-1:0]             status_w,
    input logic [DATA_W-1:0]             mask_w
);
    import evt_irq_pkg::*;

    localparam logic [DATA_W-1:0] VALID_W = DATA_W'(SRC_VALID);
    localparam logic [DATA_W-1:0] ERR_W   = DATA_W'(SRC_ERR);

    logic [DATA_W-1:0] evt_v, clr_v;
    assign evt_v = DATA_W'(evt_i) & VALID_W;
    assign clr_v = (reg_wr_i && reg_addr_i == ADDR_W'(OFF_STATUS)) ? reg_wdata_i : '0;

    a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_v) |=> ((status_w & $past(evt_v)) == $past(evt_v)));

    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_v & ~evt_v)) |=> ((status_w & $past(clr_v & ~evt_v)) == '0));

    a_r4_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_v & evt_v)) |=> ((status_w & $past(clr_v & evt_v)) == $past(clr_v & evt_v)));

    a_r5_setmask: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_W'(OFF_SETMSK))
        |=> ((mask_w & $past(reg_wdata_i & VALID_W)) == $past(reg_wdata_i & VALID_W)));

    a_r5_unmask: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_W'(OFF_UNMASK))
        |=> ((mask_w & $past(reg_wdata_i)) == '0));

    a_r6_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(status_w & ~mask_w))));

    a_r7_err_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (err_irq_o == $past(|(status_w & ~mask_w & ERR_W))));

    a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_w | mask_w) & ~VALID_W) == '0);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> (reg_rdata_o == '0));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rd_i    (reg_rd_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .err_irq_o   (err_irq_o),
    .status_w    (status_w),
    .mask_w      (mask_w)
);

// File: tb/evt_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;
    localparam logic [31:0] VALID = 32'h0000_02FF;
    localparam logic [31:0] ERRM  = 32'h0000_02E4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  evt = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic        irq, err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_stat = '0;
    logic [31:0] m_mask = VALID;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    evt_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd),
        .reg_rdata_o(rdata), .irq_o(irq), .err_irq_o(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one-cycle access: optional write plus event pulse, model updated alongside
    task automatic op(input logic [7:0] a, input logic [31:0] d, input logic w, input logic [9:0] e);
        logic [31:0] clr;
        addr = a; wdata = d; wr = w; evt = e;
        @(negedge clk);
        wr = 1'b0; evt = '0; wdata = '0;
        clr = (w && a == 8'h10) ? d : '0;
        m_stat = ((m_stat & ~clr) | {22'd0, e}) & VALID;
        if (w && a == 8'h24) m_mask = m_mask & ~d;
        if (w && a == 8'h28) m_mask = m_mask | d;
        m_mask = m_mask & VALID;
    endtask

    // driver: issue a read and push the expected value into the scoreboard
    task automatic rd_chk(input logic [7:0] a, input string tag);
        logic [31:0] e;
        e = (a == 8'h10) ? m_stat : (a == 8'h20) ? m_mask : 32'h0;
        addr = a; rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic irq_chk(input string tag);
        @(negedge clk);
        chk({tag, " irq"}, {31'd0, irq}, {31'd0, |(m_stat & ~m_mask)});
        chk({tag, " err"}, {31'd0, err}, {31'd0, |(m_stat & ~m_mask & ERRM)});
    endtask

    // monitor: pop and compare one cycle after each read strobe
    initial begin
        forever begin
            logic took;
            @(posedge clk);
            took = rd;
            @(negedge clk);
            if (took && exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, rdata, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 err", {31'd0, err}, 32'd0);
        chk("R1 rdata", rdata, 32'd0);
        rd_chk(8'h10, "R1 status");
        rd_chk(8'h20, "R1 mask");
        // R9 write-only and unmapped reads
        rd_chk(8'h24, "R9 unmask port");
        rd_chk(8'h28, "R9 mask port");
        rd_chk(8'h3C, "R9 unmapped");
        // R2 event while masked: status set, R6 no irq
        op(8'h00, 0, 1'b0, 10'h001);
        rd_chk(8'h10, "R2 done bit");
        irq_chk("R6 masked");
        // R5 unmask bit 0 -> R6 irq
        op(8'h24, 32'h1, 1'b1, '0);
        irq_chk("R6 unmasked");
        rd_chk(8'h20, "R5 mask after unmask");
        // R3 clear
        op(8'h10, 32'h1, 1'b1, '0);
        irq_chk("R3 cleared");
        rd_chk(8'h10, "R3 status cleared");
        // R8 reserved bit 8 event, R2 nack
        op(8'h00, 0, 1'b0, 10'h104);
        rd_chk(8'h10, "R8 bit8 event dropped");
        irq_chk("R7 nack masked");
        op(8'h24, 32'hFFFF_FFFF, 1'b1, '0);
        rd_chk(8'h20, "R8 mask reserved zero");
        irq_chk("R7 nack unmasked");
        // R5 mask port closes bit 2
        op(8'h28, 32'h4, 1'b1, '0);
        irq_chk("R5 masked again");
        rd_chk(8'h20, "R5 mask view");
        // R4 event with same-cycle clear
        op(8'h10, 32'h4, 1'b1, 10'h004);
        rd_chk(8'h10, "R4 event wins");
        // R3 zero write keeps bits
        op(8'h10, 32'h0, 1'b1, '0);
        rd_chk(8'h10, "R3 zero write");
        // R8 reserved write to mask port
        op(8'h28, 32'hFFFF_FD00, 1'b1, '0);
        rd_chk(8'h20, "R8 mask reserved ignore");
        // R2 all sources, R7 non-error source only
        op(8'h10, 32'hFFFF_FFFF, 1'b1, '0);
        op(8'h24, 32'h10, 1'b1, 10'h010);
        irq_chk("R7 target ready not error");
        op(8'h00, 0, 1'b0, 10'h3FF);
        rd_chk(8'h10, "R2 all sources");
        @(negedge clk);
        // R10 no read in previous cycle
        chk("R10 idle rdata", rdata, 32'd0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule